// File: doc/BRIEF.md
# SPI Slave Bit Shifter with Pause Control

This block is the serial front end of a memory device that answers on an SPI-compatible bus. It runs on a fast system clock and oversamples the chip-select, serial clock, serial input and pause pins through a short synchronizer. From the synchronized pins it assembles incoming bits into bytes, most significant bit first, and hands each finished byte to a command layer. In the other direction it shifts bytes supplied by that layer out on the serial output. The layer decides, through an output-enable input, whether the current phase drives the line at all.

Both common clock polarities are accepted: a clock that idles low and a clock that idles high. In both cases input bits are taken on the rising serial clock edge and output bits change on the falling edge. A pause pin lets the bus master stop a transfer without giving up the select. While paused, clock and data activity is ignored and the output is released. When the pause ends, the transfer picks up at the exact bit where it stopped. Releasing chip select at any time throws away a partial byte and clears the pause.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, so_oe, rx_valid and tx_req are all 0.
- R2: With SCK idling low, the byte captured from SI on eight rising SCK edges, first bit as bit 7, appears on rx_data together with rx_valid.
- R3: With SCK idling high at select time, framing is identical to R2: the first falling edge neither shifts nor counts, and bytes arrive unchanged.
- R4: SO shows bit 7 of the transmit byte before the first rising SCK edge of each byte and moves to the next lower bit after each falling edge. The following byte's bit 7 is present with no gap after the eighth rising edge.
- R5: rx_valid is high for exactly one system clock per received byte.
- R6: so_oe is 1 only while CS is asserted (low), the pause is not in effect and out_en is 1. With out_en at 0, reception still proceeds.
- R7: While the pause is in effect, SCK and SI transitions are ignored and so_oe is 0. After release, reception and transmission continue from the same bit position.
- R8: A low level on hold_n takes effect, and a high level releases the pause, only while SCK is low. A change made while SCK is high waits for SCK to fall, and that falling edge is not counted while paused.
- R9: Raising cs_n, even during a pause, discards a partial byte (no rx_valid) and clears the pause. The next selection starts at bit 7 of a new byte.
- R10: tx_req pulses for one clock each time tx_data is taken: when CS becomes asserted and on every eighth counted rising edge. The layer then presents the next byte on tx_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least several times faster than SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in pin |
| hold_n | input | 1 | Pause request pin, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for the serial data out pad |
| out_en | input | 1 | Command layer permits driving SO in the current phase |
| tx_data | input | W | Next byte to transmit, taken when tx_req pulses |
| tx_req | output | 1 | One-clock pulse: tx_data was loaded, present the next byte |
| rx_valid | output | 1 | One-clock pulse: rx_data holds a new byte |
| rx_data | output | W | Last complete received byte |

## Verification
A bit counter that is off by one shows up at the ports within one byte time: rx_data carries a rotated value and SO repeats or skips a bit at the byte boundary. A pause flag that engages or releases on the wrong SCK level either drops so_oe while SCK is high or lets an ignored clock pulse through, and the byte completed after the pause then differs from the one sent. A partial byte that survives a CS release produces an extra rx_valid or a shifted first byte in the next selection. The bench compares every SO bit and every received byte against values computed from the requirements, so each of these faults is reported at the end of the byte in which it occurs.

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         si,
  input  logic         hold_n,
  output logic         so,
  output logic         so_oe,
  input  logic         out_en,
  input  logic [W-1:0] tx_data,
  output logic         tx_req,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [SYNC:0] sck_q, si_q, cs_q, hold_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          held;

  wire sck_s    = sck_q[SYNC-1];
  wire rise     = sck_s & ~sck_q[SYNC];
  wire fall     = ~sck_s & sck_q[SYNC];
  wire active   = ~cs_q[SYNC-1];
  wire cs_start = cs_q[SYNC] & ~cs_q[SYNC-1];
  wire si_s     = si_q[SYNC-1];

  assign so    = tx_sh[W-1];
  assign so_oe = active & ~held & out_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= '0;
      si_q     <= '0;
      cs_q     <= '1;
      hold_q   <= '1;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      held     <= 1'b0;
    end else begin
      sck_q    <= {sck_q[SYNC-1:0], sck};
      si_q     <= {si_q[SYNC-1:0], si};
      cs_q     <= {cs_q[SYNC-1:0], cs_n};
      hold_q   <= {hold_q[SYNC-1:0], hold_n};
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (!active) begin
        cnt  <= '0;
        held <= 1'b0;
      end else begin
        if (!sck_s) held <= ~hold_q[SYNC-1];
        if (!held) begin
          if (rise) begin
            rx_sh <= {rx_sh[W-2:0], si_s};
            if (cnt == LAST) begin
              cnt      <= '0;
              rx_data  <= {rx_sh[W-2:0], si_s};
              rx_valid <= 1'b1;
              tx_sh    <= tx_data;
              tx_req   <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (fall && cnt != '0) begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
          end
        end
      end
      if (cs_start) begin
        tx_sh  <= tx_data;
        tx_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so_oe,
  input logic tx_req,
  input logic rx_valid
);
  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  a_r6_no_drive_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !so_oe);

  a_r9_no_byte_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !rx_valid);

  a_r7_pause_releases_so: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2) &&
     !sck && !$past(sck) && !$past(sck, 2)) |=> !so_oe);
endmodule

bind spi_hold_slave spi_hold_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so_oe(so_oe), .tx_req(tx_req), .rx_valid(rx_valid)
);

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, out_en = 1'b1;
  logic so, so_oe, tx_req, rx_valid;
  logic [7:0] rx_data, tx_data;

  logic [7:0] txs [0:255];
  logic [7:0] rx_log [0:255];
  int txi, rx_n, wide;
  logic prev_v;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_hold_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .out_en(out_en), .tx_data(tx_data), .tx_req(tx_req),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  assign tx_data = txs[txi[7:0]];

  always @(negedge clk) begin
    if (!rst_n) begin
      txi <= 0; rx_n <= 0; wide <= 0; prev_v <= 1'b0;
    end else begin
      prev_v <= rx_valid;
      if (tx_req) txi <= txi + 1;
      if (rx_valid) begin
        rx_log[rx_n[7:0]] <= rx_data;
        rx_n <= rx_n + 1;
      end
      if (rx_valid && prev_v) wide <= wide + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_tx(input logic [7:0] a, input logic [7:0] b);
    txs[txi[7:0]] = a;
    txs[(txi + 1) & 255] = b;
    txs[(txi + 2) & 255] = 8'h00;
  endtask

  task automatic sel(input bit mode);
    sck = mode; wt(4); cs_n = 1'b0; wt(HALF);
  endtask

  task automatic desel();
    wt(HALF); cs_n = 1'b1; wt(HALF);
  endtask

  task automatic bit_x(input bit mode, input bit b, output bit s, output bit oe);
    if (mode) sck = 1'b0;
    si = b; wt(HALF);
    s = so; oe = so_oe;
    sck = 1'b1; wt(HALF);
    if (!mode) sck = 1'b0;
  endtask

  task automatic byte_x(input bit mode, input logic [7:0] b, output logic [7:0] s, output bit oe_all);
    bit sb, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(mode, b[i], sb, oe);
      s[i] = sb; oe_all &= oe;
    end
  endtask

  // {mode, rx0, rx1, tx0, tx1}
  localparam logic [32:0] VEC [0:5] = '{
    {1'b0, 8'hA5, 8'h3C, 8'h5A, 8'hC3},
    {1'b1, 8'h01, 8'h80, 8'hFE, 8'h7F},
    {1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {1'b1, 8'h96, 8'h69, 8'h81, 8'h18},
    {1'b0, 8'h7E, 8'hE7, 8'hAA, 8'h55},
    {1'b1, 8'h33, 8'hCC, 8'h0F, 8'hF0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0, s1;
    bit oe0, oe1, sb, oe;
    int rb, tb;
    for (int k = 0; k < 256; k++) txs[k] = 8'h00;
    wt(6); rst_n = 1'b1; wt(2);
    chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);
    chk(so_oe == 1'b0, "R6 idle deselected", so_oe, 0);

    for (int v = 0; v < 6; v++) begin
      logic [32:0] e;
      e = VEC[v];
      set_tx(e[15:8], e[7:0]);
      rb = rx_n; tb = txi;
      sel(e[32]);
      byte_x(e[32], e[31:24], s0, oe0);
      byte_x(e[32], e[23:16], s1, oe1);
      desel();
      chk(rx_n == rb + 2, e[32] ? "R3 byte count" : "R2 byte count", rx_n - rb, 2);
      chk(rx_log[rb[7:0]] == e[31:24], e[32] ? "R3 rx byte0" : "R2 rx byte0", rx_log[rb[7:0]], e[31:24]);
      chk(rx_log[(rb + 1) & 255] == e[23:16], e[32] ? "R3 rx byte1" : "R2 rx byte1", rx_log[(rb + 1) & 255], e[23:16]);
      chk(s0 == e[15:8], "R4 so byte0", s0, e[15:8]);
      chk(s1 == e[7:0], "R4 so byte1 no gap", s1, e[7:0]);
      chk(oe0 && oe1, "R6 so_oe while selected", {oe0, oe1}, 2'b11);
      chk(txi == tb + 3, "R10 tx_req count", txi - tb, 3);
    end

    // R6: out_en low keeps SO released, reception continues
    out_en = 1'b0;
    set_tx(8'hFF, 8'hFF);
    rb = rx_n;
    sel(1'b0);
    byte_x(1'b0, 8'hD2, s0, oe0);
    desel();
    out_en = 1'b1;
    chk(!oe0 && so_oe == 1'b0, "R6 out_en low", oe0, 0);
    chk(rx_log[rb[7:0]] == 8'hD2, "R6 rx with out_en low", rx_log[rb[7:0]], 8'hD2);

    // R7: pause mid-byte, ignored clocks, resume
    set_tx(8'h3B, 8'h00);
    rb = rx_n;
    sel(1'b0);
    for (int i = 7; i >= 4; i--) begin bit_x(1'b0, 1'(8'hC6 >> i), sb, oe); s0[i] = sb; end
    hold_n = 1'b0; wt(HALF);
    chk(so_oe == 1'b0, "R7 so released in pause", so_oe, 0);
    for (int p = 0; p < 3; p++) begin
      si = p[0]; sck = 1'b1; wt(HALF); sck = 1'b0; wt(HALF);
    end
    chk(rx_n == rb, "R7 no byte during pause", rx_n - rb, 0);
    hold_n = 1'b1; wt(HALF);
    chk(so_oe == 1'b1 && so == 1'b1, "R7 resume position", {so_oe, so}, 2'b11);
    for (int i = 3; i >= 0; i--) begin bit_x(1'b0, 1'(8'hC6 >> i), sb, oe); s0[i] = sb; end
    desel();
    chk(rx_log[rb[7:0]] == 8'hC6, "R7 rx across pause", rx_log[rb[7:0]], 8'hC6);
    chk(s0 == 8'h3B, "R7 so across pause", s0, 8'h3B);

    // R8: pause changes wait for SCK low
    set_tx(8'h96, 8'h00);
    rb = rx_n;
    sel(1'b0);
    for (int i = 7; i >= 6; i--) begin bit_x(1'b0, 1'(8'h5A >> i), sb, oe); s0[i] = sb; end
    si = 1'b0; wt(HALF); s0[5] = so; sck = 1'b1; wt(4);
    hold_n = 1'b0; wt(HALF);
    chk(so_oe == 1'b1, "R8 pause deferred while SCK high", so_oe, 1);
    sck = 1'b0; wt(HALF);
    chk(so_oe == 1'b0, "R8 pause takes effect at SCK low", so_oe, 0);
    si = 1'b1; sck = 1'b1; wt(HALF);
    hold_n = 1'b1; wt(HALF);
    chk(so_oe == 1'b0, "R8 release deferred while SCK high", so_oe, 0);
    sck = 1'b0; wt(HALF);
    chk(so_oe == 1'b1 && so == 1'b1, "R8 release at SCK low", {so_oe, so}, 2'b11);
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, 1'(8'h5A >> i), sb, oe); s0[i] = sb; end
    desel();
    chk(rx_n == rb + 1 && rx_log[rb[7:0]] == 8'h5A, "R8 rx byte", rx_log[rb[7:0]], 8'h5A);
    chk(s0 == 8'h96, "R8 so byte", s0, 8'h96);

    // R9: abort partial byte
    set_tx(8'hFF, 8'hFF);
    rb = rx_n;
    sel(1'b0);
    for (int i = 0; i < 5; i++) bit_x(1'b0, 1'b1, sb, oe);
    desel();
    chk(rx_n == rb, "R9 partial byte dropped", rx_n - rb, 0);
    set_tx(8'hE1, 8'h00);
    sel(1'b0);
    byte_x(1'b0, 8'h81, s0, oe0);
    desel();
    chk(rx_n == rb + 1 && rx_log[rb[7:0]] == 8'h81, "R9 fresh byte after abort", rx_log[rb[7:0]], 8'h81);
    chk(s0 == 8'hE1, "R9 so restarts at bit 7", s0, 8'hE1);

    // R9: abort while paused
    set_tx(8'hFF, 8'hFF);
    rb = rx_n;
    sel(1'b1);
    for (int i = 0; i < 3; i++) bit_x(1'b1, 1'b1, sb, oe);
    sck = 1'b0; wt(4);
    hold_n = 1'b0; wt(HALF);
    cs_n = 1'b1; wt(HALF);
    hold_n = 1'b1; wt(HALF);
    set_tx(8'h24, 8'h00);
    sel(1'b1);
    chk(so_oe == 1'b1, "R9 pause cleared by deselect", so_oe, 1);
    byte_x(1'b1, 8'h3C, s0, oe0);
    desel();
    chk(rx_n == rb + 1 && rx_log[rb[7:0]] == 8'h3C, "R9 byte after paused abort", rx_log[rb[7:0]], 8'h3C);
    chk(s0 == 8'h24, "R9 so after paused abort", s0, 8'h24);

    chk(wide == 0, "R5 rx_valid single cycle", wide, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule